// File: doc/BRIEF.md
# Indirect Interrupt Controller Register Window

This block is the bus-facing register front end of an I/O interrupt controller. A processor reaches all internal state through two locations in a small address window. It first writes an 8-bit index into a select register, then reads or writes a 32-bit data window. The index chooses one of the following: an identifier register, a read-only version word, an arbitration word that mirrors the identifier, or one half of a 64-bit redirection entry. There is one redirection entry per interrupt input pin.

The redirection table is held in flops, and the whole table is presented on a flat output bus for the delivery logic. The block does not deliver interrupts, sample pins or handle end-of-interrupt. The delivery logic sets an entry's remote-request status bit through a side-band input. The block raises one-cycle pulses when software writes an entry, when the entry's mask bit flips, and when a written entry is level-triggered while its pin request is pending. That last pulse lets the delivery logic re-offer the interrupt. Bus accesses take one cycle, and the read data is registered.

Top module: `irq_regwin`

## Requirements
- R1: Bus offset 0x00 is the select register and offset 0x10 is the data window. Reads at any other offset return 0, and writes there change nothing.
- R2: A write to the select register keeps bits 7:0 of the write data. A read of it returns that byte in bits 7:0, with zeros above.
- R3: Index 0x01 reads as the version word. Bits 23:16 hold PIN_COUNT-1, bits 7:0 hold VERSION_CODE (default 0x11), and all other bits are 0. Writes to index 0x01 change nothing.
- R4: Index 0x00 and index 0x02 both read the 4-bit identifier in bits 27:24, with all other bits 0. A write to index 0x00 stores write-data bits 27:24. A write to index 0x02 changes nothing.
- R5: An index of 0x10 or above selects entry n = (index-0x10)>>1. An even index selects entry bits 31:0 and an odd index selects bits 63:32. Entry n appears on entry_flat bits [64n+63:64n].
- R6: Indexes 0x03 to 0x0F, and entry numbers at or above PIN_COUNT, read as 0xFFFFFFFF. Writes to them change no entry and raise no entry pulse.
- R7: Entry bit 14 is the remote-request status bit. A write to the low half forces it to 0. A write to the high half leaves it unchanged. A remote_set bit sets it. When a remote_set bit and a low-half write to the same entry fall in the same cycle, the bit ends at 1.
- R8: Entry bit 16 is the mask bit. When a write changes it, mask_chg_valid pulses for one cycle with the pin number and the new value. A write that leaves bit 16 unchanged raises no pulse.
- R9: After reset, every entry reads 0x00000000_00010000 (masked), the select register and the identifier are 0, read data is 0, and no pulse is active.
- R10: Entry bit 15 set means level-triggered. When a write leaves the entry's bit 15 at 1 and the pin's pin_pending bit is 1, redeliver_valid pulses for one cycle with that pin. For an edge-triggered entry (bit 15 at 0), redeliver_valid stays 0.
- R11: bus_len gives the access size in bytes. A write of 1 or 2 bytes uses only the low 8 or 16 bits of the write data, and 4 or 8 bytes use all 32 bits. Reads are trimmed to the same widths. Any other length makes a write change nothing and a read return 0.
- R12: Read data appears on bus_rdata in the cycle after the read request. It holds until the next read.
- R13: Every accepted entry write pulses entry_wr_valid for one cycle with the entry's pin number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request strobe |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset within the device window |
| bus_len | input | 4 | Access length in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_pending | input | PIN_COUNT | Request pending per pin, from pin sampling |
| remote_set | input | PIN_COUNT | Sets the remote-request bit of each entry |
| entry_flat | output | 64*PIN_COUNT | All redirection entries, entry n at [64n+63:64n] |
| entry_wr_valid | output | 1 | Pulse: an entry was written |
| entry_wr_pin | output | PIN_W | Pin of the written entry |
| mask_chg_valid | output | 1 | Pulse: a mask bit changed |
| mask_chg_pin | output | PIN_W | Pin whose mask changed |
| mask_chg_value | output | 1 | New mask value |
| redeliver_valid | output | 1 | Pulse: a level entry with a pending request was rewritten |
| redeliver_pin | output | PIN_W | Pin to re-offer |

## Verification
Two pairs of functions can act in the same cycle. In the first pair, one low-half write clears the remote-request bit while the delivery side sets it. The bench drives remote_set for pin 5 on the same clock as a low-half write to entry 5, and expects bit 14 to read back as 1. In the second pair, one write unmasks a level-triggered entry whose pin request is pending. The bench checks that the mask-change pulse and the redelivery pulse appear together in the cycle after that write, and that both drop one cycle later.

// File: rtl/irq_regwin_pkg.sv
package irq_regwin_pkg;

    localparam int DATA_W    = 32;
    localparam int ENTRY_W   = 64;
    localparam int INDEX_W   = 8;
    localparam int ID_W      = 4;
    localparam int LEN_W     = 4;

    localparam logic [7:0] OFF_SELECT = 8'h00;
    localparam logic [7:0] OFF_WINDOW = 8'h10;

    localparam logic [INDEX_W-1:0] IX_BASE_ID    = 8'h00;
    localparam logic [INDEX_W-1:0] IX_BASE_VER   = 8'h01;
    localparam logic [INDEX_W-1:0] IX_BASE_ARB   = 8'h02;
    localparam logic [INDEX_W-1:0] IX_BASE_TABLE = 8'h10;

    localparam int RIRR_BIT = 14;
    localparam int TRIG_BIT = 15;
    localparam int MASK_BIT = 16;
    localparam int ID_LSB   = 24;

    localparam logic [ENTRY_W-1:0] ENTRY_RESET = ENTRY_W'(1) << MASK_BIT;

    typedef enum logic [2:0] {
        IX_ID,
        IX_VER,
        IX_ARB,
        IX_ENTRY,
        IX_RSVD
    } idx_kind_e;

    typedef struct packed {
        logic [INDEX_W-1:0] sel;
        logic [ID_W-1:0]    id;
        logic [DATA_W-1:0]  rdata;
    } front_t;

    // Bit 32: length accepted; bits 31:0: byte-lane mask for that length.
    function automatic logic [DATA_W:0] len_mask(input logic [LEN_W-1:0] len);
        logic [DATA_W:0] r;
        case (len)
            4'd1:       r = {1'b1, 32'h0000_00FF};
            4'd2:       r = {1'b1, 32'h0000_FFFF};
            4'd4, 4'd8: r = {1'b1, 32'hFFFF_FFFF};
            default:    r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_regwin_decode.sv
module irq_regwin_decode
    import irq_regwin_pkg::*;
#(
    parameter int PIN_COUNT = 24,
    localparam int PIN_W = (PIN_COUNT > 1) ? $clog2(PIN_COUNT) : 1
) (
    input  logic [INDEX_W-1:0] sel,
    output idx_kind_e          kind,
    output logic [PIN_W-1:0]   pin,
    output logic               hi_half
);
    logic [INDEX_W-1:0] offset_from_table;
    logic [INDEX_W-1:0] entry_num;

    always_comb begin
        offset_from_table = sel - IX_BASE_TABLE;
        entry_num         = offset_from_table >> 1;
        pin               = entry_num[PIN_W-1:0];
        hi_half           = sel[0];
        if (sel == IX_BASE_ID) begin
            kind = IX_ID;
        end else if (sel == IX_BASE_VER) begin
            kind = IX_VER;
        end else if (sel == IX_BASE_ARB) begin
            kind = IX_ARB;
        end else if (sel < IX_BASE_TABLE) begin
            kind = IX_RSVD;
        end else if (32'(entry_num) < PIN_COUNT) begin
            kind = IX_ENTRY;
        end else begin
            kind = IX_RSVD;
        end
    end

endmodule

// File: rtl/irq_regwin_table.sv
module irq_regwin_table
    import irq_regwin_pkg::*;
#(
    parameter int PIN_COUNT = 24,
    localparam int PIN_W = (PIN_COUNT > 1) ? $clog2(PIN_COUNT) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [PIN_W-1:0]             wr_pin,
    input  logic                         wr_hi,
    input  logic [DATA_W-1:0]            wr_val,
    input  logic [PIN_COUNT-1:0]         pin_pending,
    input  logic [PIN_COUNT-1:0]         remote_set,
    output logic [PIN_COUNT*ENTRY_W-1:0] entry_flat,
    output logic                         upd_valid,
    output logic [PIN_W-1:0]             upd_pin,
    output logic                         mchg_valid,
    output logic [PIN_W-1:0]             mchg_pin,
    output logic                         mchg_val,
    output logic                         redo_valid,
    output logic [PIN_W-1:0]             redo_pin
);
    typedef struct packed {
        logic             upd_valid;
        logic [PIN_W-1:0] upd_pin;
        logic             mchg_valid;
        logic [PIN_W-1:0] mchg_pin;
        logic             mchg_val;
        logic             redo_valid;
        logic [PIN_W-1:0] redo_pin;
    } evt_t;

    logic [ENTRY_W-1:0] ent_q [PIN_COUNT];
    logic [ENTRY_W-1:0] ent_d [PIN_COUNT];
    evt_t               evt_q;
    evt_t               evt_d;
    logic [ENTRY_W-1:0] old_ent;
    logic [ENTRY_W-1:0] new_ent;

    always_comb begin
        for (int i = 0; i < PIN_COUNT; i++) begin
            ent_d[i] = ent_q[i];
        end
        evt_d   = '0;
        old_ent = ent_q[wr_pin];
        new_ent = old_ent;
        if (wr_hi) begin
            new_ent[ENTRY_W-1:DATA_W] = wr_val;
        end else begin
            new_ent[DATA_W-1:0] = wr_val;
            new_ent[RIRR_BIT]   = 1'b0;
        end
        if (wr_en) begin
            ent_d[wr_pin]   = new_ent;
            evt_d.upd_valid = 1'b1;
            evt_d.upd_pin   = wr_pin;
            if (new_ent[MASK_BIT] != old_ent[MASK_BIT]) begin
                evt_d.mchg_valid = 1'b1;
                evt_d.mchg_pin   = wr_pin;
                evt_d.mchg_val   = new_ent[MASK_BIT];
            end
            if (new_ent[TRIG_BIT] && pin_pending[wr_pin]) begin
                evt_d.redo_valid = 1'b1;
                evt_d.redo_pin   = wr_pin;
            end
        end
        // Delivery-side set is applied last, so it wins over a clearing write.
        for (int i = 0; i < PIN_COUNT; i++) begin
            if (remote_set[i]) begin
                ent_d[i][RIRR_BIT] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PIN_COUNT; i++) begin
                ent_q[i] <= ENTRY_RESET;
            end
            evt_q <= '0;
        end else begin
            for (int i = 0; i < PIN_COUNT; i++) begin
                ent_q[i] <= ent_d[i];
            end
            evt_q <= evt_d;
        end
    end

    for (genvar g = 0; g < PIN_COUNT; g++) begin : g_flat
        assign entry_flat[g*ENTRY_W +: ENTRY_W] = ent_q[g];

        // R7: low-half write without a concurrent set leaves remote bit clear
        assert_low_clears_remote_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_hi && wr_pin == PIN_W'(g) && !remote_set[g])
            |=> !ent_q[g][RIRR_BIT]);

        // R7: a set request always lands
        assert_remote_set_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
            remote_set[g] |=> ent_q[g][RIRR_BIT]);
    end

    assign upd_valid  = evt_q.upd_valid;
    assign upd_pin    = evt_q.upd_pin;
    assign mchg_valid = evt_q.mchg_valid;
    assign mchg_pin   = evt_q.mchg_pin;
    assign mchg_val   = evt_q.mchg_val;
    assign redo_valid = evt_q.redo_valid;
    assign redo_pin   = evt_q.redo_pin;

    // R8: a reported mask change matches the stored mask
    assert_mask_pulse_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q.mchg_valid |-> ent_q[evt_q.mchg_pin][MASK_BIT] == evt_q.mchg_val);

    // R10: redelivery is only offered for level-triggered entries
    assert_redo_level_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q.redo_valid |-> ent_q[evt_q.redo_pin][TRIG_BIT]);

    // R13: events come only from a write one cycle earlier
    assert_event_needs_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !evt_q.upd_valid && !evt_q.mchg_valid && !evt_q.redo_valid);

endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
    import irq_regwin_pkg::*;
#(
    parameter int PIN_COUNT = 24,
    parameter logic [7:0] VERSION_CODE = 8'h11,
    localparam int PIN_W = (PIN_COUNT > 1) ? $clog2(PIN_COUNT) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_valid,
    input  logic                         bus_write,
    input  logic [7:0]                   bus_addr,
    input  logic [LEN_W-1:0]             bus_len,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [PIN_COUNT-1:0]         pin_pending,
    input  logic [PIN_COUNT-1:0]         remote_set,
    output logic [PIN_COUNT*ENTRY_W-1:0] entry_flat,
    output logic                         entry_wr_valid,
    output logic [PIN_W-1:0]             entry_wr_pin,
    output logic                         mask_chg_valid,
    output logic [PIN_W-1:0]             mask_chg_pin,
    output logic                         mask_chg_value,
    output logic                         redeliver_valid,
    output logic [PIN_W-1:0]             redeliver_pin
);
    localparam logic [DATA_W-1:0] VERSION_WORD =
        {8'h00, 8'(PIN_COUNT - 1), 8'h00, VERSION_CODE};

    front_t             s_q;
    front_t             s_d;
    idx_kind_e          dec_kind;
    logic [PIN_W-1:0]   dec_pin;
    logic               dec_hi;
    logic [DATA_W:0]    lm;
    logic               len_ok;
    logic [DATA_W-1:0]  wdata_m;
    logic               tbl_wr;
    logic [ENTRY_W-1:0] sel_entry;
    logic [DATA_W-1:0]  rd_res;

    irq_regwin_decode #(.PIN_COUNT(PIN_COUNT)) i_decode (
        .sel     (s_q.sel),
        .kind    (dec_kind),
        .pin     (dec_pin),
        .hi_half (dec_hi)
    );

    irq_regwin_table #(.PIN_COUNT(PIN_COUNT)) i_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (tbl_wr),
        .wr_pin      (dec_pin),
        .wr_hi       (dec_hi),
        .wr_val      (wdata_m),
        .pin_pending (pin_pending),
        .remote_set  (remote_set),
        .entry_flat  (entry_flat),
        .upd_valid   (entry_wr_valid),
        .upd_pin     (entry_wr_pin),
        .mchg_valid  (mask_chg_valid),
        .mchg_pin    (mask_chg_pin),
        .mchg_val    (mask_chg_value),
        .redo_valid  (redeliver_valid),
        .redo_pin    (redeliver_pin)
    );

    always_comb begin
        s_d       = s_q;
        tbl_wr    = 1'b0;
        lm        = len_mask(bus_len);
        len_ok    = lm[DATA_W];
        wdata_m   = bus_wdata & lm[DATA_W-1:0];
        sel_entry = entry_flat[int'(dec_pin)*ENTRY_W +: ENTRY_W];
        rd_res    = '0;

        if (bus_valid && bus_write && len_ok) begin
            if (bus_addr == OFF_SELECT) begin
                s_d.sel = wdata_m[INDEX_W-1:0];
            end else if (bus_addr == OFF_WINDOW) begin
                case (dec_kind)
                    IX_ID:    s_d.id = wdata_m[ID_LSB +: ID_W];
                    IX_ENTRY: tbl_wr = 1'b1;
                    default:  ;
                endcase
            end
        end

        if (bus_addr == OFF_SELECT) begin
            rd_res = DATA_W'(s_q.sel);
        end else if (bus_addr == OFF_WINDOW) begin
            case (dec_kind)
                IX_ID, IX_ARB: rd_res = DATA_W'(s_q.id) << ID_LSB;
                IX_VER:        rd_res = VERSION_WORD;
                IX_ENTRY:      rd_res = dec_hi ? sel_entry[ENTRY_W-1:DATA_W]
                                               : sel_entry[DATA_W-1:0];
                default:       rd_res = '1;
            endcase
        end

        if (bus_valid && !bus_write) begin
            s_d.rdata = rd_res & lm[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;

    // R2: the select register keeps the low byte of an accepted write
    assert_select_low_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == OFF_SELECT && len_ok)
        |=> s_q.sel == $past(bus_wdata[7:0]));

    // R3: a full-width version read returns the fixed word
    assert_version_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == OFF_WINDOW && s_q.sel == IX_BASE_VER
         && bus_len == 4'd4)
        |=> bus_rdata == VERSION_WORD);

    // R6: a write to a reserved index leaves the table untouched
    assert_reserved_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == OFF_WINDOW && dec_kind == IX_RSVD
         && remote_set == '0)
        |=> $stable(entry_flat));

    // R11: an unsupported length changes no register
    assert_bad_len_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !len_ok)
        |=> $stable(s_q.sel) && $stable(s_q.id) && !entry_wr_valid);

    // R12: read data holds while no read is requested
    assert_rdata_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));

endmodule

// File: tb/test_irq_regwin.sv
`timescale 1ns/1ps
module test_irq_regwin;
    localparam int P = 24;
    localparam int PW = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_valid = 1'b0;
    logic           bus_write = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [3:0]     bus_len = 4'd4;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [P-1:0]   pin_pending = '0;
    logic [P-1:0]   remote_set = '0;
    logic [P*64-1:0] entry_flat;
    logic           entry_wr_valid;
    logic [PW-1:0]  entry_wr_pin;
    logic           mask_chg_valid;
    logic [PW-1:0]  mask_chg_pin;
    logic           mask_chg_value;
    logic           redeliver_valid;
    logic [PW-1:0]  redeliver_pin;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [P*64-1:0] snap;

    always #2.5 clk = ~clk;

    irq_regwin i_irq_regwin (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_pending(pin_pending), .remote_set(remote_set),
        .entry_flat(entry_flat), .entry_wr_valid(entry_wr_valid),
        .entry_wr_pin(entry_wr_pin), .mask_chg_valid(mask_chg_valid),
        .mask_chg_pin(mask_chg_pin), .mask_chg_value(mask_chg_value),
        .redeliver_valid(redeliver_valid), .redeliver_pin(redeliver_pin)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [3:0] len,
                          input logic [31:0] d, input logic [P-1:0] rset);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_len = len;
        bus_wdata = d; remote_set = rset;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; remote_set = '0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [3:0] len,
                          input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_len = len;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic rd_idx(input logic [7:0] idx, input logic [31:0] exp, input string tag);
        bus_wr(8'h00, 4'd4, 32'(idx), '0);
        bus_rd(8'h10, 4'd4, exp, tag);
    endtask

    task automatic wr_idx(input logic [7:0] idx, input logic [31:0] d);
        bus_wr(8'h00, 4'd4, 32'(idx), '0);
        bus_wr(8'h10, 4'd4, d, '0);
    endtask

    // Monitor: pops the expected read value and compares it the cycle after the request.
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && bus_valid && !bus_write) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R12 unexpected read actual=%h expected=none", bus_rdata);
                end else begin
                    chk(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
                end
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int masked;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        masked = 0;
        for (int i = 0; i < P; i++) begin
            if (entry_flat[i*64 +: 64] == 64'h0000_0000_0001_0000) masked++;
        end
        chk("R9 all entries masked", 64'(masked), 64'(P));
        chk("R9 no pulses", {mask_chg_valid, redeliver_valid, entry_wr_valid}, 0);
        chk("R9 read data zero", 64'(bus_rdata), 0);
        bus_rd(8'h00, 4'd4, 32'h0, "R9 select reset");
        bus_rd(8'h10, 4'd4, 32'h0, "R9 identifier reset");

        // R2 select keeps low byte
        bus_wr(8'h00, 4'd4, 32'h1234_5601, '0);
        bus_rd(8'h00, 4'd4, 32'h0000_0001, "R2 select low byte");

        // R1 other offsets
        bus_wr(8'h04, 4'd4, 32'h0000_0077, '0);
        bus_rd(8'h00, 4'd4, 32'h0000_0001, "R1 write to other offset ignored");
        bus_rd(8'h20, 4'd4, 32'h0, "R1 other offset reads zero");

        // R3 version
        rd_idx(8'h01, 32'h0017_0011, "R3 version word");
        bus_wr(8'h10, 4'd4, 32'hFFFF_FFFF, '0);
        bus_rd(8'h10, 4'd4, 32'h0017_0011, "R3 version write ignored");

        // R4 identifier
        wr_idx(8'h00, 32'hA500_0000);
        bus_rd(8'h10, 4'd4, 32'h0500_0000, "R4 identifier stored");
        wr_idx(8'h02, 32'h0300_0000);
        bus_rd(8'h10, 4'd4, 32'h0500_0000, "R4 arbitration mirrors identifier");
        rd_idx(8'h00, 32'h0500_0000, "R4 arbitration write ignored");

        // R5 / R8 / R13 pin 3
        wr_idx(8'h16, 32'h0000_A0C5);
        chk("R8 mask pulse valid", 64'(mask_chg_valid), 1);
        chk("R8 mask pulse pin/value", {mask_chg_pin, mask_chg_value}, {5'd3, 1'b0});
        chk("R13 write pulse pin 3", {entry_wr_valid, entry_wr_pin}, {1'b1, 5'd3});
        @(negedge clk);
        chk("R8 pulse one cycle", {mask_chg_valid, entry_wr_valid}, 0);
        wr_idx(8'h17, 32'hFF00_0000);
        chk("R8 no pulse when mask unchanged", 64'(mask_chg_valid), 0);
        chk("R13 high write pulse", {entry_wr_valid, entry_wr_pin}, {1'b1, 5'd3});
        chk("R5 entry 3 on flat bus", entry_flat[3*64 +: 64], 64'hFF00_0000_0000_A0C5);
        rd_idx(8'h16, 32'h0000_A0C5, "R5 entry 3 low half");
        rd_idx(8'h17, 32'hFF00_0000, "R5 entry 3 high half");

        // R10 redelivery, same cycle as mask change
        pin_pending[5] = 1'b1;
        pin_pending[6] = 1'b1;
        wr_idx(8'h1A, 32'h0000_8031);
        chk("R10 redeliver pin 5", {redeliver_valid, redeliver_pin}, {1'b1, 5'd5});
        chk("R8 mask pulse with redeliver", {mask_chg_valid, mask_chg_pin}, {1'b1, 5'd5});
        @(negedge clk);
        chk("R10 redeliver one cycle", 64'(redeliver_valid), 0);
        wr_idx(8'h1C, 32'h0000_0031);
        chk("R10 edge entry no redeliver", 64'(redeliver_valid), 0);

        // R7 remote-request bit
        @(negedge clk); remote_set[5] = 1'b1;
        @(negedge clk); remote_set[5] = 1'b0;
        rd_idx(8'h1A, 32'h0000_C031, "R7 remote set");
        wr_idx(8'h1B, 32'h0100_0000);
        rd_idx(8'h1A, 32'h0000_C031, "R7 high write keeps remote");
        bus_wr(8'h10, 4'd4, 32'h0000_8031, '0);
        chk("R7 low write clears remote", entry_flat[5*64 +: 64], 64'h0100_0000_0000_8031);
        bus_wr(8'h10, 4'd4, 32'h0000_8031, 24'(1) << 5);
        chk("R7 set wins over clear", entry_flat[5*64 +: 64], 64'h0100_0000_0000_C031);

        // R6 reserved indexes
        rd_idx(8'h05, 32'hFFFF_FFFF, "R6 index 0x05");
        rd_idx(8'h40, 32'hFFFF_FFFF, "R6 index 0x40");
        rd_idx(8'h41, 32'hFFFF_FFFF, "R6 index 0x41");
        snap = entry_flat;
        bus_wr(8'h10, 4'd4, 32'h0, '0);
        chk("R6 reserved write no pulse", 64'(entry_wr_valid), 0);
        chk("R6 reserved write no change", 64'(entry_flat == snap), 1);

        // R11 lengths on pin 8 low half (index 0x20)
        wr_idx(8'h20, 32'h0000_0000);
        bus_wr(8'h10, 4'd1, 32'h1234_5678, '0);
        bus_rd(8'h10, 4'd4, 32'h0000_0078, "R11 byte write");
        bus_wr(8'h10, 4'd2, 32'hFFFF_ABCD, '0);
        bus_rd(8'h10, 4'd4, 32'h0000_ABCD, "R11 halfword write");
        bus_wr(8'h10, 4'd3, 32'h0000_0001, '0);
        chk("R11 bad length no write pulse", 64'(entry_wr_valid), 0);
        bus_rd(8'h10, 4'd8, 32'h0000_ABCD, "R11 bad length write ignored");
        bus_rd(8'h10, 4'd1, 32'h0000_00CD, "R11 byte read");
        bus_rd(8'h10, 4'd2, 32'h0000_ABCD, "R11 halfword read");
        bus_rd(8'h10, 4'd3, 32'h0000_0000, "R11 bad length read");

        // R12 read data holds
        bus_rd(8'h00, 4'd4, 32'h0000_0020, "R12 select read");
        bus_wr(8'h00, 4'd4, 32'h0000_0001, '0);
        repeat (2) @(negedge clk);
        chk("R12 read data held", 64'(bus_rdata), 64'h20);

        repeat (3) @(negedge clk);
        chk("R12 all reads consumed", 64'(exp_q.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule